// File: doc/BRIEF.md
# Serial Controller CPU Bus Interface

This block is the processor-facing register port of an 8-bit serial controller. A processor reaches it through an active-low chip select, active-low read and write strobes and one register-select line. The select line chooses between the data path (low) and the control path (high). Together with the strobe, it picks one of four accesses: read the received character, write the transmit holding register, read the status byte, or write the command register. When the chip is not selected, or no single strobe is active, the bus driver is off and the registers keep their contents.

The bidirectional bus is split into an input, an output and an output-enable, and a pad or top-level tristate joins them. A write is taken on the leading edge of its strobe. That edge becomes a one-clock load pulse, and the register is updated on the same edge as the pulse. The pulse and the register contents go to the serial engine. The command register also drives two active-low modem handshake outputs: terminal-ready from command bit 1 and request-to-send from command bit 5. The active-low data-set-ready input is synchronised to the clock and shown, inverted, as status bit 7. Status bits 6..0 come from the serial engine unchanged.

Top module: `usart_bus_if`

## Requirements
- R1: With cs_n=0, sel=0, rd_n=0 and wr_n=1, bus_oe is 1 and bus_out equals rx_char in the same cycle.
- R2: With cs_n=0, sel=1, rd_n=0 and wr_n=1, bus_oe is 1 and bus_out is {status bit 7, stat_in[6:0]} in the same cycle.
- R3: A data write (cs_n=0, sel=0, wr_n=0, rd_n=1) loads bus_in into tx_hold and raises tx_load for exactly one cycle, both visible one clock after the strobe is first seen. A strobe held longer gives no further pulse.
- R4: A control write (cs_n=0, sel=1, wr_n=0, rd_n=1) loads bus_in into cmd_word and raises cmd_load for exactly one cycle, one clock after the strobe is first seen. cmd_word changes only together with cmd_load.
- R5: While cs_n=1, bus_oe is 0, and strobes cause no load pulse and no register change.
- R6: While cs_n=0 and both rd_n and wr_n are 1, bus_oe is 0.
- R7: dtr_n is the inverse of cmd_word bit 1, and rts_n is the inverse of cmd_word bit 5.
- R8: Status bit 7 is the inverse of dsr_n, delayed by SYNC_STAGES (default 2) clocks.
- R9: Reset clears cmd_word and tx_hold, holds tx_load and cmd_load at 0, and drives dtr_n and rts_n to 1.
- R10: With rd_n and wr_n both 0, the access is ignored: bus_oe is 0, no pulse is produced and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sel | input | 1 | Register select: 1 control/status, 0 data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 8 | Bus value presented by the processor |
| bus_out | output | 8 | Bus value driven back during reads |
| bus_oe | output | 1 | Bus driver enable |
| rx_char | input | 8 | Received character from the serial engine |
| stat_in | input | 7 | Status bits 6..0 from the serial engine |
| dsr_n | input | 1 | Data-set-ready input, active low |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| tx_hold | output | 8 | Transmit holding register |
| tx_load | output | 1 | One-cycle pulse when tx_hold is written |
| cmd_word | output | 8 | Command register |
| cmd_load | output | 1 | One-cycle pulse when cmd_word is written |

## Verification
A wrong value in the strobe-history flop shows up one clock after the strobe as a missing pulse or a repeated pulse. A stale or corrupted command register shows up at once on dtr_n and rts_n, and on cmd_word. A slip in the synchroniser moves the change of status bit 7 by a cycle, so the bench samples that bit on the exact cycle the change is expected and on the cycle before it. Read steering is combinational, so a decode fault shows on bus_out or bus_oe in the same cycle as the strobe.

// File: rtl/usart_bus_pkg.sv
package usart_bus_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RD_DATA,
        ACC_WR_DATA,
        ACC_RD_STAT,
        ACC_WR_CMD
    } access_e;

endpackage

// File: rtl/usart_bus_decode.sv
module usart_bus_decode
    import usart_bus_pkg::*;
(
    input  logic    cs_n,
    input  logic    sel,
    input  logic    rd_n,
    input  logic    wr_n,
    output access_e access
);

    always_comb begin
        access = ACC_NONE;
        if (!cs_n) begin
            if (!rd_n && wr_n) begin
                access = sel ? ACC_RD_STAT : ACC_RD_DATA;
            end else if (rd_n && !wr_n) begin
                access = sel ? ACC_WR_CMD : ACC_WR_DATA;
            end
        end
    end

endmodule

// File: rtl/usart_bus_sync.sv
module usart_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_val,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign chain_d[i] = async_in;
            end else begin : g_next
                assign chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{rst_val}};
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/usart_bus_if.sv
module usart_bus_if
    import usart_bus_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DTR_BIT     = 1,
    parameter int RTS_BIT     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sel,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] rx_char,
    input  logic [DATA_W-2:0] stat_in,
    input  logic              dsr_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic [DATA_W-1:0] tx_hold,
    output logic              tx_load,
    output logic [DATA_W-1:0] cmd_word,
    output logic              cmd_load
);

    localparam int DSR_BIT = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] thr;
        logic              wr_seen;
        logic              tx_pulse;
        logic              cmd_pulse;
    } regs_t;

    regs_t   r_d, r_q;
    access_e access;
    logic    dsr_n_sync;
    logic    wr_now;
    logic [DATA_W-1:0] status_byte;

    usart_bus_decode u_decode (
        .cs_n   (cs_n),
        .sel    (sel),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .access (access)
    );

    usart_bus_sync #(.STAGES(SYNC_STAGES)) u_dsr_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_val  (1'b1),
        .async_in (dsr_n),
        .sync_out (dsr_n_sync)
    );

    assign wr_now = (access == ACC_WR_DATA) || (access == ACC_WR_CMD);

    always_comb begin
        r_d           = r_q;
        r_d.wr_seen   = wr_now;
        r_d.tx_pulse  = 1'b0;
        r_d.cmd_pulse = 1'b0;
        if (wr_now && !r_q.wr_seen) begin
            if (access == ACC_WR_CMD) begin
                r_d.cmd       = bus_in;
                r_d.cmd_pulse = 1'b1;
            end else begin
                r_d.thr      = bus_in;
                r_d.tx_pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        status_byte          = '0;
        status_byte[DSR_BIT] = ~dsr_n_sync;
        status_byte[DATA_W-2:0] = stat_in;
        bus_oe  = (access == ACC_RD_DATA) || (access == ACC_RD_STAT);
        bus_out = '0;
        if (access == ACC_RD_DATA)      bus_out = rx_char;
        else if (access == ACC_RD_STAT) bus_out = status_byte;
    end

    assign tx_hold  = r_q.thr;
    assign tx_load  = r_q.tx_pulse;
    assign cmd_word = r_q.cmd;
    assign cmd_load = r_q.cmd_pulse;
    assign dtr_n    = ~r_q.cmd[DTR_BIT];
    assign rts_n    = ~r_q.cmd[RTS_BIT];

    // R3: a load pulse never lasts two cycles
    a_r3_tx_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);

    // R4: command register only moves with its pulse
    a_r4_cmd_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_load |-> $stable(cmd_word));

    // R3/R4: one access never loads both registers
    a_r4_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_load && cmd_load));

    // R5: deselected strobes leave no pulse
    a_r5_no_pulse_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !(tx_load || cmd_load));

    // R5/R6/R10: driver off without a single active read strobe
    a_r6_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n || !wr_n) |-> !bus_oe);

    // R10: conflicting strobes write nothing
    a_r10_no_write_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !wr_n) |=> !(tx_load || cmd_load));

    // R7: modem outputs track the command register
    a_r7_modem_follow: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load |-> (dtr_n != cmd_word[DTR_BIT]) && (rts_n != cmd_word[RTS_BIT]));

endmodule

// File: tb/usart_bus_if_bench.sv
module usart_bus_if_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] bus_in = '0, rx_char = '0;
    logic [6:0] stat_in = '0;
    logic       dsr_n = 1'b1;
    logic [7:0] bus_out, tx_hold, cmd_word;
    logic       bus_oe, dtr_n, rts_n, tx_load, cmd_load;

    usart_bus_if u_usart_bus_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sel(sel), .rd_n(rd_n), .wr_n(wr_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .rx_char(rx_char),
        .stat_in(stat_in), .dsr_n(dsr_n), .dtr_n(dtr_n), .rts_n(rts_n),
        .tx_hold(tx_hold), .tx_load(tx_load), .cmd_word(cmd_word), .cmd_load(cmd_load)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef enum int { S_BUS, S_OE, S_THR, S_CMD, S_DTR, S_RTS, S_TXL, S_CMDL } sig_e;
    typedef struct {
        int    due;
        sig_e  which;
        logic [7:0] val;
        string tag;
    } item_t;

    item_t exp_q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] observe(sig_e w);
        case (w)
            S_BUS:  return bus_out;
            S_OE:   return {7'd0, bus_oe};
            S_THR:  return tx_hold;
            S_CMD:  return cmd_word;
            S_DTR:  return {7'd0, dtr_n};
            S_RTS:  return {7'd0, rts_n};
            S_TXL:  return {7'd0, tx_load};
            default: return {7'd0, cmd_load};
        endcase
    endfunction

    // driver side: queue an expectation d cycles from now
    task automatic expect_at(int d, sig_e w, logic [7:0] v, string tag);
        item_t it;
        it.due = cyc + d; it.which = w; it.val = v; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: compare due items away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            for (int i = exp_q.size() - 1; i >= 0; i--) begin
                if (exp_q[i].due <= cyc) begin
                    logic [7:0] got;
                    got = observe(exp_q[i].which);
                    checks++;
                    if (got !== exp_q[i].val) begin
                        fails++;
                        $display("FAIL %s sig=%0d actual=%h expected=%h", exp_q[i].tag,
                                 exp_q[i].which, got, exp_q[i].val);
                    end
                    exp_q.delete(i);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    // write with strobe held 'hold' cycles; checks pulse and register
    task automatic do_write(logic s, logic [7:0] v, int hold, string tag);
        cs_n = 1'b0; sel = s; rd_n = 1'b1; wr_n = 1'b0; bus_in = v;
        expect_at(1, s ? S_CMDL : S_TXL, 8'd1, tag);
        expect_at(1, s ? S_CMD : S_THR, v, tag);
        for (int k = 1; k < hold; k++) begin
            step();
            expect_at(1, s ? S_CMDL : S_TXL, 8'd0, tag);
        end
        step();
        idle();
        step();
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        // R9: reset state
        expect_at(0, S_CMD, 8'h00, "R9");
        expect_at(0, S_THR, 8'h00, "R9");
        expect_at(0, S_DTR, 8'd1, "R9");
        expect_at(0, S_RTS, 8'd1, "R9");
        expect_at(0, S_TXL, 8'd0, "R9");
        expect_at(0, S_OE, 8'd0, "R9");
        step();

        // R3: data write, strobe held 3 cycles
        do_write(1'b0, 8'hA5, 3, "R3");
        do_write(1'b0, 8'h3C, 1, "R3");

        // R4 and R7: command writes
        do_write(1'b1, 8'h02, 2, "R4");
        expect_at(0, S_DTR, 8'd0, "R7"); expect_at(0, S_RTS, 8'd1, "R7");
        step();
        do_write(1'b1, 8'h20, 1, "R4");
        expect_at(0, S_DTR, 8'd1, "R7"); expect_at(0, S_RTS, 8'd0, "R7");
        expect_at(0, S_CMDL, 8'd0, "R4");
        step();

        // R1: data read
        rx_char = 8'h5E;
        cs_n = 1'b0; sel = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
        expect_at(0, S_OE, 8'd1, "R1"); expect_at(0, S_BUS, 8'h5E, "R1");
        step();
        rx_char = 8'hC3;
        expect_at(0, S_BUS, 8'hC3, "R1");
        step();

        // R2 and R8: status read, dsr low then sampled after sync delay
        sel = 1'b1; stat_in = 7'h15;
        expect_at(0, S_BUS, 8'h15, "R2");
        step();
        dsr_n = 1'b0;
        expect_at(0, S_BUS, 8'h15, "R8");
        expect_at(1, S_BUS, 8'h15, "R8");
        expect_at(2, S_BUS, 8'h95, "R8");
        step(); step(); step();
        stat_in = 7'h6A;
        expect_at(0, S_BUS, 8'hEA, "R2");
        step();

        // R6: selected, no strobe
        rd_n = 1'b1; wr_n = 1'b1;
        expect_at(0, S_OE, 8'd0, "R6");
        step();

        // R10: both strobes low
        rd_n = 1'b0; wr_n = 1'b0; sel = 1'b0; bus_in = 8'hFF;
        expect_at(0, S_OE, 8'd0, "R10");
        expect_at(1, S_TXL, 8'd0, "R10");
        expect_at(1, S_THR, 8'h3C, "R10");
        step(); step();
        idle(); step();

        // R5: deselected write and read attempts
        cs_n = 1'b1; sel = 1'b1; wr_n = 1'b0; bus_in = 8'hFF;
        expect_at(1, S_CMDL, 8'd0, "R5");
        expect_at(1, S_CMD, 8'h20, "R5");
        step();
        wr_n = 1'b1; rd_n = 1'b0;
        expect_at(0, S_OE, 8'd0, "R5");
        step();
        sel = 1'b0; rd_n = 1'b1; wr_n = 1'b0;
        expect_at(1, S_THR, 8'h3C, "R5");
        expect_at(1, S_TXL, 8'd0, "R5");
        step(); idle(); step();

        // R9: reset again after registers are written
        do_write(1'b1, 8'hFF, 1, "R4");
        rst_n = 1'b0;
        expect_at(0, S_CMD, 8'h00, "R9");
        expect_at(0, S_DTR, 8'd1, "R9");
        expect_at(0, S_RTS, 8'd1, "R9");
        step();
        rst_n = 1'b1;
        step(); step(); step();
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard actual=%0d expected=0 leftover items", exp_q.size());
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule